// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block holds the pending state of the private interrupts of one processor: 16 software-generated interrupts (IDs 0 to 15) and 16 per-processor peripheral lines (IDs 16 to 31). Peripheral lines are sampled every clock. A line configured as edge-triggered latches a pending bit when it rises. A line configured as level-sensitive shows as pending for as long as it is held high. Software-generated requests arrive with an ID, a requested group and a non-secure flag. A request latches a pending bit only when the requested group fits the configured group of the target and, for non-secure requests while security is enabled, when the per-ID access field permits it.

Software clears pending latches through a clear mask. The block drives a registered effective pending vector, which serves both register reads and signalling. It also drives a registered interrupt request that is high when some pending, enabled and inactive interrupt exists. Register decoding and selection of the highest-priority interrupt sit in neighbouring blocks.

Top module: `pip_pending`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_o` and `irq_o` become 0 and the remembered level of every peripheral line becomes 0.
- R2: One clock after the inputs are sampled, `pend_o[k]` for a peripheral ID k (16..31) equals its latch OR (`ppi_lvl_i[k-16]` AND NOT `edge_cfg_i[k-16]`). `pend_o[k]` for an ID below 16 equals its latch.
- R3: On an edge-triggered line (`edge_cfg_i` bit = 1), a latch is set only when the line is 1 at a clock edge and was 0 at the previous edge. A line that stays high, or that falls, sets nothing. A level-sensitive line never sets its latch.
- R4: A 1 in `clr_i[k]` clears latch k. A level-sensitive line that is still high keeps `pend_o[k]` at 1.
- R5: The requested group `sgi_grp_i` is encoded 0 = Group 0, 1 = secure Group 1, 2 = non-secure Group 1, 3 = invalid. The configured group of SGI n is non-secure Group 1 when `grp_i[n]`=1, secure Group 1 when `grp_i[n]`=0 and `grpmod_i[n]`=1, and Group 0 otherwise. A secure Group 1 request aimed at a Group 0 target counts as Group 0. Any other mismatch, and code 3, drops the request.
- R6: When `sgi_ns_i`=1 and `sec_dis_i`=0, the access field is `nsacc_i[2n+1:2n]`. A Group 0 target needs a field value of at least 1, and a secure Group 1 target needs at least 2, or the request is dropped. A non-secure Group 1 target, a secure request, or disabled security skips this check.
- R7: A request that passes R5 and R6 sets latch `sgi_id_i`.
- R8: When a set and a clear reach the same latch bit in one cycle, the bit ends up set.
- R9: One clock after sampling, `irq_o` is 1 exactly when some bit of (next effective pending AND `en_i` AND NOT `act_i`) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppi_lvl_i | input | 16 | Peripheral line levels, bit j is ID 16+j |
| edge_cfg_i | input | 16 | 1 = edge-triggered, 0 = level-sensitive, per peripheral line |
| grp_i | input | 16 | Group bit per SGI |
| grpmod_i | input | 16 | Group modifier bit per SGI |
| nsacc_i | input | 32 | Two-bit non-secure access field per SGI |
| sec_dis_i | input | 1 | 1 = security disabled |
| sgi_req_i | input | 1 | SGI request valid |
| sgi_id_i | input | 4 | Target SGI ID |
| sgi_grp_i | input | 2 | Requested group code |
| sgi_ns_i | input | 1 | Request comes from the non-secure side |
| clr_i | input | 32 | Latch clear mask |
| en_i | input | 32 | Enable per ID |
| act_i | input | 32 | Active per ID |
| pend_o | output | 32 | Registered effective pending vector |
| irq_o | output | 1 | Registered request: some pending, enabled, inactive ID |

## Verification
The bench sweeps every target ID against every configured group, requested code, security side, access field value and security setting. A gate that forgot the secure-Group-1-to-Group-0 remap would drop requests that should be accepted. A gate that checked access at the wrong threshold or field would accept or refuse the boundary values 1 and 2 wrongly. On the peripheral side it targets a line held high across a clear, which must not re-latch when edge-triggered but must still show when level-sensitive. It also targets a clear that coincides with a rise, where a clear-priority latch would lose the event. A long stretch of varied traffic compares the vector and the request line every cycle against a model written from the requirements.

// File: rtl/pip_pkg.sv
package pip_pkg;
  typedef enum logic [1:0] {
    GRP_ZERO = 2'd0,
    GRP_ONE_S = 2'd1,
    GRP_ONE_NS = 2'd2,
    GRP_BAD = 2'd3
  } grp_e;

  localparam logic [1:0] ACC_MIN_ZERO = 2'd1;
  localparam logic [1:0] ACC_MIN_ONE_S = 2'd2;
endpackage

// File: rtl/pip_sgi_gate.sv
module pip_sgi_gate
  import pip_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int IDW = $clog2(NUM_SGI)
) (
  input  logic               req_v,
  input  logic [IDW-1:0]     req_id,
  input  grp_e               req_grp,
  input  logic               req_ns,
  input  logic               sec_dis,
  input  logic [NUM_SGI-1:0] grp_bits,
  input  logic [NUM_SGI-1:0] mod_bits,
  input  logic [2*NUM_SGI-1:0] nsacc,
  output logic [NUM_SGI-1:0] set_vec
);
  grp_e       cfg_grp;
  grp_e       eff_grp;
  logic [1:0] fld;
  logic       grp_ok;
  logic       perm_ok;

  always_comb begin
    if (grp_bits[req_id])      cfg_grp = GRP_ONE_NS;
    else if (mod_bits[req_id]) cfg_grp = GRP_ONE_S;
    else                       cfg_grp = GRP_ZERO;

    if (req_grp == GRP_ONE_S && cfg_grp == GRP_ZERO) eff_grp = GRP_ZERO;
    else                                             eff_grp = req_grp;
    grp_ok = (eff_grp == cfg_grp);

    fld = nsacc[2*req_id +: 2];
    if (!req_ns || sec_dis) perm_ok = 1'b1;
    else begin
      case (cfg_grp)
        GRP_ZERO:  perm_ok = (fld >= ACC_MIN_ZERO);
        GRP_ONE_S: perm_ok = (fld >= ACC_MIN_ONE_S);
        default:   perm_ok = 1'b1;
      endcase
    end

    set_vec = '0;
    if (req_v && grp_ok && perm_ok) set_vec[req_id] = 1'b1;
  end
endmodule

// File: rtl/pip_ppi_edge.sv
module pip_ppi_edge #(
  parameter int NUM_PPI = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PPI-1:0] lvl_i,
  output logic [NUM_PPI-1:0] rise_o
);
  logic [NUM_PPI-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pip_latch_bank.sv
module pip_latch_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] bit_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign nxt_o[i] = set_i[i] | (bit_q[i] & ~clr_i[i]);
    always_ff @(posedge clk) begin
      if (rst) bit_q[i] <= 1'b0;
      else     bit_q[i] <= nxt_o[i];
    end
  end
endmodule

// File: rtl/pip_pending.sv
module pip_pending
  import pip_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int NUM_ALL = NUM_SGI + NUM_PPI,
  localparam int IDW = $clog2(NUM_SGI)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PPI-1:0]   ppi_lvl_i,
  input  logic [NUM_PPI-1:0]   edge_cfg_i,
  input  logic [NUM_SGI-1:0]   grp_i,
  input  logic [NUM_SGI-1:0]   grpmod_i,
  input  logic [2*NUM_SGI-1:0] nsacc_i,
  input  logic                 sec_dis_i,
  input  logic                 sgi_req_i,
  input  logic [IDW-1:0]       sgi_id_i,
  input  logic [1:0]           sgi_grp_i,
  input  logic                 sgi_ns_i,
  input  logic [NUM_ALL-1:0]   clr_i,
  input  logic [NUM_ALL-1:0]   en_i,
  input  logic [NUM_ALL-1:0]   act_i,
  output logic [NUM_ALL-1:0]   pend_o,
  output logic                 irq_o
);
  logic [NUM_SGI-1:0] sgi_set;
  logic [NUM_PPI-1:0] ppi_rise;
  logic [NUM_ALL-1:0] set_all;
  logic [NUM_ALL-1:0] latch_nxt;
  logic [NUM_ALL-1:0] pend_d;

  pip_sgi_gate #(.NUM_SGI(NUM_SGI)) u_gate (
    .req_v    (sgi_req_i),
    .req_id   (sgi_id_i),
    .req_grp  (grp_e'(sgi_grp_i)),
    .req_ns   (sgi_ns_i),
    .sec_dis  (sec_dis_i),
    .grp_bits (grp_i),
    .mod_bits (grpmod_i),
    .nsacc    (nsacc_i),
    .set_vec  (sgi_set)
  );

  pip_ppi_edge #(.NUM_PPI(NUM_PPI)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (ppi_lvl_i),
    .rise_o (ppi_rise)
  );

  assign set_all = {ppi_rise & edge_cfg_i, sgi_set};

  pip_latch_bank #(.WIDTH(NUM_ALL)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_all),
    .clr_i (clr_i),
    .nxt_o (latch_nxt)
  );

  assign pend_d = latch_nxt | {ppi_lvl_i & ~edge_cfg_i, {NUM_SGI{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      irq_o  <= |(pend_d & en_i & ~act_i);
    end
  end
endmodule

// File: rtl/pip_pending_chk.sv
module pip_pending_chk #(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int NUM_ALL = NUM_SGI + NUM_PPI,
  localparam int IDW = $clog2(NUM_SGI)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PPI-1:0]   ppi_lvl_i,
  input logic [NUM_PPI-1:0]   edge_cfg_i,
  input logic [NUM_SGI-1:0]   grp_i,
  input logic [NUM_SGI-1:0]   grpmod_i,
  input logic [2*NUM_SGI-1:0] nsacc_i,
  input logic                 sec_dis_i,
  input logic                 sgi_req_i,
  input logic [IDW-1:0]       sgi_id_i,
  input logic [1:0]           sgi_grp_i,
  input logic                 sgi_ns_i,
  input logic [NUM_ALL-1:0]   clr_i,
  input logic [NUM_ALL-1:0]   en_i,
  input logic [NUM_ALL-1:0]   act_i,
  input logic [NUM_ALL-1:0]   pend_o,
  input logic                 irq_o
);
  logic [NUM_PPI-1:0] prev_q, rise_exp, lvl_exp;
  logic [NUM_ALL-1:0] ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      rise_exp <= '0;
      lvl_exp  <= '0;
      ready_q  <= '0;
    end else begin
      prev_q   <= ppi_lvl_i;
      rise_exp <= ppi_lvl_i & ~prev_q & edge_cfg_i;
      lvl_exp  <= ppi_lvl_i & ~edge_cfg_i;
      ready_q  <= en_i & ~act_i;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_o == '0 && !irq_o)); // R1
  AST_LEVEL_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (pend_o[NUM_ALL-1:NUM_SGI] & lvl_exp) == lvl_exp); // R2
  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (pend_o[NUM_ALL-1:NUM_SGI] & rise_exp) == rise_exp); // R3
  AST_GROUP_MISMATCH_DROPS: assert property (@(posedge clk) disable iff (rst)
    (sgi_req_i && sgi_grp_i == 2'd2 && !grp_i[sgi_id_i] && !grpmod_i[sgi_id_i]
     && !pend_o[sgi_id_i]) |=> !pend_o[$past(sgi_id_i)]); // R5
  AST_NS_ACCESS_DENIED: assert property (@(posedge clk) disable iff (rst)
    (sgi_req_i && sgi_ns_i && !sec_dis_i && sgi_grp_i == 2'd0 && !grp_i[sgi_id_i]
     && !grpmod_i[sgi_id_i] && nsacc_i[2*sgi_id_i +: 2] == 2'd0 && !pend_o[sgi_id_i])
    |=> !pend_o[$past(sgi_id_i)]); // R6
  AST_NS_GROUP1_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (sgi_req_i && sgi_grp_i == 2'd2 && grp_i[sgi_id_i]) |=> pend_o[$past(sgi_id_i)]); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sgi_req_i && !sgi_ns_i && sgi_grp_i == 2'd0 && !grp_i[sgi_id_i]
     && !grpmod_i[sgi_id_i] && clr_i[sgi_id_i]) |=> pend_o[$past(sgi_id_i)]); // R8
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(pend_o & ready_q)); // R9
endmodule

bind pip_pending pip_pending_chk #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_chk (
  .clk(clk), .rst(rst), .ppi_lvl_i(ppi_lvl_i), .edge_cfg_i(edge_cfg_i),
  .grp_i(grp_i), .grpmod_i(grpmod_i), .nsacc_i(nsacc_i), .sec_dis_i(sec_dis_i),
  .sgi_req_i(sgi_req_i), .sgi_id_i(sgi_id_i), .sgi_grp_i(sgi_grp_i),
  .sgi_ns_i(sgi_ns_i), .clr_i(clr_i), .en_i(en_i), .act_i(act_i),
  .pend_o(pend_o), .irq_o(irq_o)
);

// File: tb/tb_pip_pending.sv
`timescale 1ns/1ps
module tb_pip_pending;
  localparam int NS = 16;
  localparam int NP = 16;
  localparam int NA = NS + NP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]   ppi = '0, edg = '0;
  logic [NS-1:0]   grp = '0, gmod = '0;
  logic [2*NS-1:0] acc = '0;
  logic            sdis = 1'b0, sreq = 1'b0, sns = 1'b0;
  logic [3:0]      sid = '0;
  logic [1:0]      sgrp = '0;
  logic [NA-1:0]   clr = '0, en = '0, act = '0;
  logic [NA-1:0]   pend;
  logic            irq;

  logic [NA-1:0] m_latch = '0, m_pend = '0;
  logic [NP-1:0] m_prev = '0;
  logic          m_irq = 1'b0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pip_pending dut (
    .clk(clk), .rst(rst), .ppi_lvl_i(ppi), .edge_cfg_i(edg), .grp_i(grp),
    .grpmod_i(gmod), .nsacc_i(acc), .sec_dis_i(sdis), .sgi_req_i(sreq),
    .sgi_id_i(sid), .sgi_grp_i(sgrp), .sgi_ns_i(sns), .clr_i(clr),
    .en_i(en), .act_i(act), .pend_o(pend), .irq_o(irq)
  );

  // Acceptance model from R5 and R6: 0 = group drop, 1 = access drop, 2 = accepted
  function automatic int sgi_verdict(input int id, input logic [1:0] rg, input logic ns);
    int cfg, eg, f;
    cfg = grp[id] ? 2 : (gmod[id] ? 1 : 0);
    eg  = (rg == 2'd1 && cfg == 0) ? 0 : int'(rg);
    if (eg != cfg) return 0;
    f = int'(acc[2*id +: 2]);
    if (ns && !sdis) begin
      if (cfg == 0 && f < 1) return 1;
      if (cfg == 1 && f < 2) return 1;
    end
    return 2;
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [NA-1:0] a, input logic [NA-1:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic cyc(input string tag);
    logic [NA-1:0] setv;
    @(posedge clk);
    if (rst) begin
      m_latch = '0; m_prev = '0; m_pend = '0; m_irq = 1'b0;
    end else begin
      setv = {ppi & ~m_prev & edg, {NS{1'b0}}};
      if (sreq && sgi_verdict(int'(sid), sgrp, sns) == 2) setv[sid] = 1'b1;
      m_latch = (m_latch & ~clr) | setv;
      m_prev  = ppi;
      m_pend  = m_latch | {ppi & ~edg, {NS{1'b0}}};
      m_irq   = |(m_pend & en & ~act);
    end
    @(negedge clk);
    chk(tag, pend === m_pend, pend, m_pend);
    chk("R9", irq === m_irq, {{(NA-1){1'b0}}, irq}, {{(NA-1){1'b0}}, m_irq});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset clears everything even with stimulus present
    ppi = '1; edg = '1; en = '1;
    cyc("R1"); cyc("R1");
    chk("R1", pend === '0, pend, '0);
    rst = 1'b0; ppi = '0; edg = '0;
    cyc("R2");

    // R2 and R4: level line visible while high, survives a clear, gone after drop
    ppi[3] = 1'b1; en[19] = 1'b1;
    cyc("R2");
    chk("R2", pend[19] === 1'b1, pend, m_pend);
    clr[19] = 1'b1;
    cyc("R4");
    chk("R4", pend[19] === 1'b1, pend, m_pend);
    clr = '0; ppi[3] = 1'b0;
    cyc("R2");
    chk("R2", pend[19] === 1'b0, pend, m_pend);

    // R3: edge line latches on rise, held after fall, no relatch while held high
    edg[5] = 1'b1; ppi[5] = 1'b1;
    cyc("R3");
    chk("R3", pend[21] === 1'b1, pend, m_pend);
    clr[21] = 1'b1;
    cyc("R3");
    chk("R3", pend[21] === 1'b0, pend, m_pend);
    clr = '0;
    cyc("R3");
    chk("R3", pend[21] === 1'b0, pend, m_pend);
    ppi[5] = 1'b0;
    cyc("R3");

    // R8: rise and clear on the same bit in one cycle
    ppi[5] = 1'b1; clr[21] = 1'b1;
    cyc("R8");
    chk("R8", pend[21] === 1'b1, pend, m_pend);
    clr = '0; ppi = '0;
    cyc("R8");

    // R8: SGI accepted while its bit is cleared
    sreq = 1'b1; sid = 4'd7; sgrp = 2'd0; sns = 1'b0; clr[7] = 1'b1;
    cyc("R8");
    chk("R8", pend[7] === 1'b1, pend, m_pend);
    sreq = 1'b0; clr = '1;
    cyc("R4");
    clr = '0;

    // Exhaustive SGI gate sweep (R5, R6, R7)
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 3; c++)
        for (int a = 0; a < 4; a++)
          for (int id = 0; id < NS; id++)
            for (int rg = 0; rg < 4; rg++)
              for (int n = 0; n < 2; n++) begin
                int v;
                sdis = s[0]; grp = (c == 2) ? '1 : '0; gmod = (c == 1) ? '1 : '0;
                acc = {NS{a[1:0]}};
                clr = '1; sreq = 1'b0;
                cyc("R4");
                clr = '0; sreq = 1'b1; sid = id[3:0]; sgrp = rg[1:0]; sns = n[0];
                v = sgi_verdict(id, rg[1:0], n[0]);
                cyc(v == 0 ? "R5" : (v == 1 ? "R6" : "R7"));
                sreq = 1'b0;
              end

    // Mixed traffic against the model (R2, R3, R4, R8, R9)
    clr = '1; cyc("R4");
    for (int k = 0; k < 3000; k++) begin
      ppi  = NP'($urandom);
      if (k % 64 == 0) edg = NP'($urandom);
      grp  = NS'($urandom); gmod = NS'($urandom); acc = $urandom;
      sdis = $urandom_range(0, 1); sreq = $urandom_range(0, 1);
      sid  = 4'($urandom); sgrp = 2'($urandom); sns = $urandom_range(0, 1);
      clr  = $urandom & $urandom & $urandom;
      en   = $urandom; act = $urandom;
      cyc("R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule